// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits beside the downstream port of a bridge between two local buses. For each lookup it decides whether an address belongs to one of three forwarding windows: an I/O window, a non-prefetchable memory window and a prefetchable memory window. It can also claim the legacy display-adapter ranges. The window bounds are built from raw configuration register fields presented on input ports. Those fields are the base and limit registers, their upper-address extensions, the I/O and memory space enables, and a legacy-display enable bit.

A lookup is one cycle with `req_valid` high, carrying a space type and a 64-bit address. One clock later the block returns a valid strobe, a hit flag and a 2-bit code that names the matching window. The register fields are sampled in the cycle of the lookup, so any update applies to the next lookup.

Top module: `bwd_top`

## Requirements
- R1: A lookup with `req_valid` high produces `hit_valid` high exactly one clock later. In any cycle that follows a cycle without a lookup, `hit_valid` and `hit` are low.
- R2: The I/O window base is `(io_base_cfg & 0xF0) << 8`. The I/O window limit is `(io_limit_cfg & 0xF0) << 8` with bits 11:0 forced to ones. When bit 0 of a register is clear, address bits 31:16 of that bound are zero.
- R3: When bit 0 of `io_base_cfg` is set, `io_base_upper` supplies base address bits 31:16. In the same way, bit 0 of `io_limit_cfg` makes `io_limit_upper` supply limit bits 31:16.
- R4: The non-prefetchable window base is `(mem_base_cfg & 0xFFF0) << 16`. Its limit is `(mem_limit_cfg & 0xFFF0) << 16` with bits 19:0 forced to ones. Address bits 63:32 of both bounds are zero.
- R5: The prefetchable window is built like the non-prefetchable one from `pf_base_cfg` and `pf_limit_cfg`. When bit 0 of a register is set, the matching `*_upper` port supplies address bits 63:32; otherwise those bits are zero.
- R6: A window whose limit is below its base never hits.
- R7: The I/O window hits only when `cmd_io_en` is high. Both memory windows hit only when `cmd_mem_en` is high.
- R8: When `vga_en` is high, memory addresses 0xA0000–0xBFFFF hit with code 3. So do I/O addresses whose low 10 bits fall in 0x3B0–0x3BB or 0x3C0–0x3DF, whatever the other address bits are. These ranges do not depend on the command enables.
- R9: `hit_code` is 0 for the I/O window, 1 for non-prefetchable, 2 for prefetchable and 3 for the legacy ranges. The priority order is prefetchable, then non-prefetchable, then legacy, and the I/O window takes priority over the legacy I/O ranges. `hit_code` is 0 when `hit` is low.
- R10: An I/O lookup (`req_space` = 0) never matches a memory window, and a memory lookup (`req_space` = 1) never matches the I/O window.
- R11: A change to any register field input takes effect for the next lookup issued after the change.
- R12: After reset, `hit_valid`, `hit` and `hit_code` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_space | input | 1 | 0 = I/O, 1 = memory |
| req_addr | input | 64 | Lookup address |
| io_base_cfg | input | 8 | I/O base register; [7:4] address, [0] 32-bit flag |
| io_limit_cfg | input | 8 | I/O limit register; [7:4] address, [0] 32-bit flag |
| io_base_upper | input | 16 | I/O base bits 31:16 |
| io_limit_upper | input | 16 | I/O limit bits 31:16 |
| mem_base_cfg | input | 16 | Non-prefetchable base; [15:4] address |
| mem_limit_cfg | input | 16 | Non-prefetchable limit; [15:4] address |
| pf_base_cfg | input | 16 | Prefetchable base; [15:4] address, [0] 64-bit flag |
| pf_limit_cfg | input | 16 | Prefetchable limit; [15:4] address, [0] 64-bit flag |
| pf_base_upper | input | 32 | Prefetchable base bits 63:32 |
| pf_limit_upper | input | 32 | Prefetchable limit bits 63:32 |
| cmd_io_en | input | 1 | I/O space enable |
| cmd_mem_en | input | 1 | Memory space enable |
| vga_en | input | 1 | Legacy display range enable |
| hit_valid | output | 1 | Result strobe, one clock after a lookup |
| hit | output | 1 | Address claimed |
| hit_code | output | 2 | Matching window code |

## Verification
Every result is due at the clock edge after the lookup: the request goes in at a falling edge, one rising edge loads the output register, and the bench reads the outputs at the next falling edge. Register fields are changed at a falling edge before the lookup that should see them. That lets the bench test that an update applies with no extra delay. The idle check reads the outputs one more falling edge later, after a cycle with no request, and expects them low.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int ADDR_W        = 64;
    localparam int IO_GRAN_BITS  = 12;
    localparam int MEM_GRAN_BITS = 20;
    localparam int VGA_IO_BITS   = 10;
    localparam int NUM_WIN       = 3;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t VGA_MEM_LO = 64'h0000_0000_000A_0000;
    localparam addr_t VGA_MEM_HI = 64'h0000_0000_000B_FFFF;
    localparam logic [VGA_IO_BITS-1:0] VGA_IO_A_LO = 10'h3B0;
    localparam logic [VGA_IO_BITS-1:0] VGA_IO_A_HI = 10'h3BB;
    localparam logic [VGA_IO_BITS-1:0] VGA_IO_B_LO = 10'h3C0;
    localparam logic [VGA_IO_BITS-1:0] VGA_IO_B_HI = 10'h3DF;

    typedef enum logic {
        SPACE_IO  = 1'b0,
        SPACE_MEM = 1'b1
    } space_e;

    typedef enum logic [1:0] {
        WIN_IO   = 2'd0,
        WIN_MEM  = 2'd1,
        WIN_PREF = 2'd2,
        WIN_VGA  = 2'd3
    } win_code_e;

    typedef struct packed {
        addr_t     base;
        addr_t     limit;
        logic      enable;
        space_e    space;
        win_code_e code;
    } window_t;

    typedef struct packed {
        logic      hit;
        win_code_e code;
    } result_t;

    // I/O bound: address nibble from [7:4], optional upper half from the extension
    function automatic addr_t io_bound(input logic [7:0] cfg,
                                       input logic [15:0] upper,
                                       input logic fill);
        addr_t a;
        a = addr_t'(cfg & 8'hF0) << 8;
        if (cfg[0])
            a[31:16] = upper;
        if (fill)
            a[IO_GRAN_BITS-1:0] = '1;
        return a;
    endfunction

    // 32-bit memory bound
    function automatic addr_t mem_bound(input logic [15:0] cfg,
                                        input logic fill);
        addr_t a;
        a = addr_t'(cfg & 16'hFFF0) << 16;
        if (fill)
            a[MEM_GRAN_BITS-1:0] = '1;
        return a;
    endfunction

    // Prefetchable bound with optional 64-bit extension
    function automatic addr_t pref_bound(input logic [15:0] cfg,
                                         input logic [31:0] upper,
                                         input logic fill);
        addr_t a;
        a = addr_t'(cfg & 16'hFFF0) << 16;
        if (cfg[0])
            a[63:32] = upper;
        if (fill)
            a[MEM_GRAN_BITS-1:0] = '1;
        return a;
    endfunction

endpackage

// File: rtl/bwd_window_match.sv
module bwd_window_match
    import bwd_pkg::*;
(
    input  window_t win,
    input  space_e  req_space,
    input  addr_t   req_addr,
    output logic    match
);
    logic nonempty;
    logic above_base;
    logic below_limit;

    always_comb begin
        nonempty    = win.limit >= win.base;
        above_base  = req_addr >= win.base;
        below_limit = req_addr <= win.limit;
        match       = win.enable && nonempty && (req_space == win.space)
                      && above_base && below_limit;
    end
endmodule

// File: rtl/bwd_vga_decode.sv
module bwd_vga_decode
    import bwd_pkg::*;
(
    input  logic   vga_en,
    input  space_e req_space,
    input  addr_t  req_addr,
    output logic   match
);
    logic [VGA_IO_BITS-1:0] io_low;
    logic io_a, io_b, mem_hit;

    always_comb begin
        io_low  = req_addr[VGA_IO_BITS-1:0];
        io_a    = (io_low >= VGA_IO_A_LO) && (io_low <= VGA_IO_A_HI);
        io_b    = (io_low >= VGA_IO_B_LO) && (io_low <= VGA_IO_B_HI);
        mem_hit = (req_addr >= VGA_MEM_LO) && (req_addr <= VGA_MEM_HI);
        if (!vga_en)
            match = 1'b0;
        else if (req_space == SPACE_IO)
            match = io_a || io_b;
        else
            match = mem_hit;
    end
endmodule

// File: rtl/bwd_top.sv
module bwd_top
    import bwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_space,
    input  logic [63:0] req_addr,
    input  logic [7:0]  io_base_cfg,
    input  logic [7:0]  io_limit_cfg,
    input  logic [15:0] io_base_upper,
    input  logic [15:0] io_limit_upper,
    input  logic [15:0] mem_base_cfg,
    input  logic [15:0] mem_limit_cfg,
    input  logic [15:0] pf_base_cfg,
    input  logic [15:0] pf_limit_cfg,
    input  logic [31:0] pf_base_upper,
    input  logic [31:0] pf_limit_upper,
    input  logic        cmd_io_en,
    input  logic        cmd_mem_en,
    input  logic        vga_en,
    output logic        hit_valid,
    output logic        hit,
    output logic [1:0]  hit_code
);
    window_t            win [NUM_WIN];
    logic [NUM_WIN-1:0] win_match;
    logic               vga_match;
    space_e             space;
    result_t            res_d, res_q;
    logic               valid_q;

    assign space = space_e'(req_space);

    // Window index order is the priority order: lowest index wins
    always_comb begin
        win[0].base   = pref_bound(pf_base_cfg, pf_base_upper, 1'b0);
        win[0].limit  = pref_bound(pf_limit_cfg, pf_limit_upper, 1'b1);
        win[0].enable = cmd_mem_en;
        win[0].space  = SPACE_MEM;
        win[0].code   = WIN_PREF;

        win[1].base   = mem_bound(mem_base_cfg, 1'b0);
        win[1].limit  = mem_bound(mem_limit_cfg, 1'b1);
        win[1].enable = cmd_mem_en;
        win[1].space  = SPACE_MEM;
        win[1].code   = WIN_MEM;

        win[2].base   = io_bound(io_base_cfg, io_base_upper, 1'b0);
        win[2].limit  = io_bound(io_limit_cfg, io_limit_upper, 1'b1);
        win[2].enable = cmd_io_en;
        win[2].space  = SPACE_IO;
        win[2].code   = WIN_IO;
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        bwd_window_match u_match (
            .win       (win[g]),
            .req_space (space),
            .req_addr  (req_addr),
            .match     (win_match[g])
        );
    end

    bwd_vga_decode u_vga (
        .vga_en    (vga_en),
        .req_space (space),
        .req_addr  (req_addr),
        .match     (vga_match)
    );

    always_comb begin
        res_d = '{hit: 1'b0, code: WIN_IO};
        if (vga_match)
            res_d = '{hit: 1'b1, code: WIN_VGA};
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_match[i])
                res_d = '{hit: 1'b1, code: win[i].code};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '{hit: 1'b0, code: WIN_IO};
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                res_q <= res_d;
            else
                res_q <= '{hit: 1'b0, code: WIN_IO};
        end
    end

    assign hit_valid = valid_q;
    assign hit       = res_q.hit;
    assign hit_code  = res_q.code;

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker
    import bwd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_space,
    input logic       cmd_io_en,
    input logic       cmd_mem_en,
    input logic       vga_en,
    input logic       hit_valid,
    input logic       hit,
    input logic [1:0] hit_code
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> hit_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!hit_valid && !hit));

    assert_io_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && hit_code == WIN_IO) |-> $past(cmd_io_en));

    assert_mem_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && (hit_code == WIN_MEM || hit_code == WIN_PREF)) |-> $past(cmd_mem_en));

    assert_vga_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (hit && hit_code == WIN_VGA) |-> $past(vga_en));

    assert_io_space_R10: assert property (@(posedge clk) disable iff (rst)
        (hit && hit_code == WIN_IO) |-> !$past(req_space));

    assert_mem_space_R10: assert property (@(posedge clk) disable iff (rst)
        (hit && (hit_code == WIN_MEM || hit_code == WIN_PREF)) |-> $past(req_space));

    assert_code_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_code == 2'd0));
endmodule

bind bwd_top bwd_checker i_bwd_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_space  (req_space),
    .cmd_io_en  (cmd_io_en),
    .cmd_mem_en (cmd_mem_en),
    .vga_en     (vga_en),
    .hit_valid  (hit_valid),
    .hit        (hit),
    .hit_code   (hit_code)
);

// File: tb/test_bwd_top.sv
module test_bwd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_space = 1'b0;
    logic [63:0] req_addr = '0;
    logic [7:0]  io_base_cfg, io_limit_cfg;
    logic [15:0] io_base_upper, io_limit_upper;
    logic [15:0] mem_base_cfg, mem_limit_cfg, pf_base_cfg, pf_limit_cfg;
    logic [31:0] pf_base_upper, pf_limit_upper;
    logic        cmd_io_en, cmd_mem_en, vga_en;
    logic        hit_valid, hit;
    logic [1:0]  hit_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic IO = 1'b0, MEM = 1'b1;

    always #5 clk = ~clk;

    bwd_top i_bwd_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_space(req_space),
        .req_addr(req_addr), .io_base_cfg(io_base_cfg), .io_limit_cfg(io_limit_cfg),
        .io_base_upper(io_base_upper), .io_limit_upper(io_limit_upper),
        .mem_base_cfg(mem_base_cfg), .mem_limit_cfg(mem_limit_cfg),
        .pf_base_cfg(pf_base_cfg), .pf_limit_cfg(pf_limit_cfg),
        .pf_base_upper(pf_base_upper), .pf_limit_upper(pf_limit_upper),
        .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .vga_en(vga_en),
        .hit_valid(hit_valid), .hit(hit), .hit_code(hit_code)
    );

    task automatic close_all();
        io_base_cfg = 8'hF0;  io_limit_cfg = 8'h00;
        io_base_upper = '0;   io_limit_upper = '0;
        mem_base_cfg = 16'hFFF0; mem_limit_cfg = 16'h0000;
        pf_base_cfg = 16'hFFF0;  pf_limit_cfg = 16'h0000;
        pf_base_upper = '0;   pf_limit_upper = '0;
        cmd_io_en = 1'b1; cmd_mem_en = 1'b1; vga_en = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual {valid,hit,code}=%b expected %b", req, what, act, exp);
        end
    endtask

    // One lookup; result read one falling edge later
    task automatic look(input logic sp, input logic [63:0] a, input logic eh,
                        input logic [1:0] ec, input string req);
        logic [3:0] act, exp;
        @(negedge clk);
        req_valid = 1'b1; req_space = sp; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        act = {hit_valid, hit, hit_code};
        exp = {1'b1, eh, eh ? ec : 2'd0};
        check(act == exp, req, $sformatf("addr=%h space=%0d", a, sp), act, exp);
    endtask

    task automatic t_reset();
        check({hit_valid, hit, hit_code} == 4'b0, "R12", "reset state",
              {hit_valid, hit, hit_code}, 4'b0);
    endtask

    task automatic t_timing();
        close_all();
        vga_en = 1'b1;
        look(MEM, 64'hA0000, 1'b1, 2'd3, "R1");
        @(negedge clk);
        check({hit_valid, hit} == 2'b00, "R1", "idle after lookup",
              {hit_valid, hit, hit_code}, 4'b0);
    endtask

    task automatic t_io16();
        close_all();
        io_base_cfg = 8'h20; io_limit_cfg = 8'h30;
        io_base_upper = 16'h0012; io_limit_upper = 16'h0012;
        look(IO, 64'h2000, 1'b1, 2'd0, "R2");
        look(IO, 64'h3FFF, 1'b1, 2'd0, "R2");
        look(IO, 64'h4000, 1'b0, 2'd0, "R2");
        look(IO, 64'h1FFF, 1'b0, 2'd0, "R2");
        look(IO, 64'h0012_2000, 1'b0, 2'd0, "R2");
    endtask

    task automatic t_io32();
        close_all();
        io_base_cfg = 8'h21; io_limit_cfg = 8'h21;
        io_base_upper = 16'h0012; io_limit_upper = 16'h0012;
        look(IO, 64'h0012_2ABC, 1'b1, 2'd0, "R3");
        look(IO, 64'h0012_2FFF, 1'b1, 2'd0, "R3");
        look(IO, 64'h0000_2ABC, 1'b0, 2'd0, "R3");
    endtask

    task automatic t_mem();
        close_all();
        mem_base_cfg = 16'h1230; mem_limit_cfg = 16'h1240;
        look(MEM, 64'h1230_0000, 1'b1, 2'd1, "R4");
        look(MEM, 64'h124F_FFFF, 1'b1, 2'd1, "R4");
        look(MEM, 64'h1250_0000, 1'b0, 2'd0, "R4");
        look(MEM, 64'h1_1230_0000, 1'b0, 2'd0, "R4");
    endtask

    task automatic t_pref();
        close_all();
        pf_base_cfg = 16'h8001; pf_limit_cfg = 16'h8FF1;
        pf_base_upper = 32'h2; pf_limit_upper = 32'h2;
        look(MEM, 64'h2_8800_0000, 1'b1, 2'd2, "R5");
        look(MEM, 64'h0_8800_0000, 1'b0, 2'd0, "R5");
        pf_base_cfg = 16'h4000; pf_limit_cfg = 16'h40F0;
        pf_base_upper = 32'h5; pf_limit_upper = 32'h5;
        look(MEM, 64'h0_4000_0000, 1'b1, 2'd2, "R5");
        look(MEM, 64'h5_4000_0000, 1'b0, 2'd0, "R5");
    endtask

    task automatic t_empty();
        close_all();
        mem_base_cfg = 16'h5000; mem_limit_cfg = 16'h4000;
        look(MEM, 64'h5000_0000, 1'b0, 2'd0, "R6");
        look(MEM, 64'h4000_0000, 1'b0, 2'd0, "R6");
        io_base_cfg = 8'h50; io_limit_cfg = 8'h40;
        look(IO, 64'h5000, 1'b0, 2'd0, "R6");
    endtask

    task automatic t_enables();
        close_all();
        mem_base_cfg = 16'h1000; mem_limit_cfg = 16'h1000;
        io_base_cfg = 8'h10; io_limit_cfg = 8'h10;
        cmd_mem_en = 1'b0;
        look(MEM, 64'h1000_0000, 1'b0, 2'd0, "R7");
        look(IO, 64'h1000, 1'b1, 2'd0, "R7");
        cmd_mem_en = 1'b1; cmd_io_en = 1'b0;
        look(IO, 64'h1000, 1'b0, 2'd0, "R7");
        look(MEM, 64'h1000_0000, 1'b1, 2'd1, "R7");
    endtask

    task automatic t_vga();
        close_all();
        vga_en = 1'b1; cmd_io_en = 1'b0; cmd_mem_en = 1'b0;
        look(MEM, 64'hA0000, 1'b1, 2'd3, "R8");
        look(MEM, 64'hBFFFF, 1'b1, 2'd3, "R8");
        look(MEM, 64'hC0000, 1'b0, 2'd0, "R8");
        look(IO, 64'h3B0, 1'b1, 2'd3, "R8");
        look(IO, 64'h3BB, 1'b1, 2'd3, "R8");
        look(IO, 64'h3BC, 1'b0, 2'd0, "R8");
        look(IO, 64'h3DF, 1'b1, 2'd3, "R8");
        look(IO, 64'h3E0, 1'b0, 2'd0, "R8");
        look(IO, 64'h13C0, 1'b1, 2'd3, "R8");
        vga_en = 1'b0;
        look(IO, 64'h3C0, 1'b0, 2'd0, "R8");
        look(MEM, 64'hA0000, 1'b0, 2'd0, "R8");
    endtask

    task automatic t_priority();
        close_all();
        vga_en = 1'b1;
        mem_base_cfg = 16'h4000; mem_limit_cfg = 16'h40F0;
        pf_base_cfg = 16'h4000;  pf_limit_cfg = 16'h40F0;
        look(MEM, 64'h4000_1000, 1'b1, 2'd2, "R9");
        mem_base_cfg = 16'h0000; mem_limit_cfg = 16'h0000;
        look(MEM, 64'hA0000, 1'b1, 2'd1, "R9");
        io_base_cfg = 8'h00; io_limit_cfg = 8'h00;
        look(IO, 64'h3C0, 1'b1, 2'd0, "R9");
    endtask

    task automatic t_space();
        close_all();
        mem_base_cfg = 16'h0000; mem_limit_cfg = 16'h0000;
        look(IO, 64'h2000, 1'b0, 2'd0, "R10");
        io_base_cfg = 8'h00; io_limit_cfg = 8'h00;
        cmd_mem_en = 1'b0;
        look(MEM, 64'h0800, 1'b0, 2'd0, "R10");
    endtask

    task automatic t_update();
        close_all();
        mem_base_cfg = 16'h2000; mem_limit_cfg = 16'h2000;
        look(MEM, 64'h2000_0000, 1'b1, 2'd1, "R11");
        mem_base_cfg = 16'h2010; mem_limit_cfg = 16'h2010;
        look(MEM, 64'h2000_0000, 1'b0, 2'd0, "R11");
        look(MEM, 64'h2010_0000, 1'b1, 2'd1, "R11");
    endtask

    initial begin
        close_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timing();
        t_io16();
        t_io32();
        t_mem();
        t_pref();
        t_empty();
        t_enables();
        t_vga();
        t_priority();
        t_space();
        t_update();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule